// File: doc/BRIEF.md
# Grayscale Frame Capture with Diagonal Checksum

This block sits between a grayscale camera and downstream logic. On a start command it asks the camera for a frame by holding an active-low request line low for a fixed time. The pulse length is given in nanoseconds and converted to clock cycles from a clock-period parameter. After the pulse, the camera delivers one whole pixel on every clock, row by row, with no gaps. The default frame is 1024 rows by 1024 columns of 10-bit pixels.

The all-ones pixel code is not allowed. Any pixel with that value is replaced by the value one below it before it is used. The block adds up the corrected pixels whose row index equals their column index. It shows that sum on a checksum port that is always driven. The port reads all ones until the sum is complete.

Two flags tell downstream logic where the capture stands: one is high while pixels are being received, and one is high when the frame's sum is final. An abort input cancels whatever is in progress, at any time.

Top module: `img_diag_capture`

## Requirements
- R1: After reset, `frame_req_n` is 1, `busy_rx` and `sum_ready` are 0, and `diag_sum` is all ones.
- R2: A `start` sampled high while idle, or while a finished sum is held, drives `frame_req_n` low from the next cycle. It stays low for exactly ceil(REQ_NS / CLK_PERIOD_NS) cycles. `start` has no effect while a request or a reception is under way.
- R3: `busy_rx` rises on the cycle after the request pulse ends. It stays high for exactly ROWS × COLS cycles.
- R4: One pixel is taken from `pix_in` on every clock edge while `busy_rx` is high, in row-major order. The first pixel taken is row 0, column 0, and the column index advances fastest.
- R5: A pixel equal to 2^PIX_W − 1 is counted as 2^PIX_W − 2. Every other pixel value is counted unchanged.
- R6: When the frame completes, `diag_sum` equals the sum of the corrected pixels at positions where the row index equals the column index.
- R7: Whenever `sum_ready` is 0, `diag_sum` reads all ones (2^SUM_W − 1).
- R8: `sum_ready` rises on the cycle after the last pixel (row ROWS−1, column COLS−1) is taken. It then holds, with `diag_sum` unchanged, until `abort` or a new `start` arrives.
- R9: An `abort` sampled high in any state returns the block to idle on the next cycle. `frame_req_n` is then 1, `busy_rx` and `sum_ready` are 0, and `diag_sum` reads all ones. `abort` wins over a simultaneous `start`.
- R10: A frame started after a completed or aborted frame computes its sum from zero. No value carries over from the earlier frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new capture (sampled on the clock edge) |
| abort | input | 1 | Cancel the current operation and return to idle |
| pix_in | input | PIX_W | Pixel from the camera, one per clock during reception |
| frame_req_n | output | 1 | Active-low frame request to the camera |
| busy_rx | output | 1 | High while frame pixels are being taken |
| sum_ready | output | 1 | High while a complete diagonal sum is held |
| diag_sum | output | SUM_W | Diagonal checksum, or all ones while not ready |

## Verification
A wrong row or column counter shows up in two ways at the ports. The frame ends early or late, which moves the rise of `sum_ready` away from cycle ROWS × COLS after `busy_rx` rises. Or the wrong pixels are treated as diagonal, which spoils the sum; frame patterns with distinct diagonal values expose this the moment the sum is released. A miscounted request timer changes the width of the low pulse on `frame_req_n` at once. An accumulator that is not cleared, or a substitution fault, shows up as a wrong `diag_sum` on the first cycle `sum_ready` is high. A state that survives `abort` shows up one cycle after the abort, as a flag still high or a checksum that is not all ones.

// File: rtl/imgcap_pkg.sv
package imgcap_pkg;

   typedef enum logic [1:0] {
      CAP_IDLE = 2'd0,
      CAP_REQ  = 2'd1,
      CAP_RECV = 2'd2,
      CAP_HOLD = 2'd3
   } cap_state_t;

   function automatic int unsigned div_ceil(input int unsigned num, input int unsigned den);
      return (num + den - 1) / den;
   endfunction

   function automatic int unsigned bits_for(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/req_pulse_timer.sv
module req_pulse_timer #(
   parameter int unsigned PULSE_CYC = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic last
);
   localparam int unsigned CW = imgcap_pkg::bits_for(PULSE_CYC);

   generate
      if (PULSE_CYC < 1) begin : g_bad
         $error("req_pulse_timer: PULSE_CYC must be at least 1");
      end

      if (PULSE_CYC == 1) begin : g_single
         assign last = run;
      end else begin : g_count
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!run || last) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign last = run && (cnt_q == CW'(PULSE_CYC - 1));
      end
   endgenerate

endmodule

// File: rtl/raster_tracker.sv
module raster_tracker #(
   parameter int unsigned ROWS = 1024,
   parameter int unsigned COLS = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   output logic on_diag,
   output logic last_pix
);
   localparam int unsigned RW = imgcap_pkg::bits_for(ROWS);
   localparam int unsigned CW = imgcap_pkg::bits_for(COLS);
   localparam int unsigned IW = (RW > CW) ? RW : CW;

   logic [RW-1:0] row_q;
   logic [CW-1:0] col_q;
   logic          row_end;
   logic          col_end;

   assign col_end  = (col_q == CW'(COLS - 1));
   assign row_end  = (row_q == RW'(ROWS - 1));
   assign last_pix = row_end && col_end;
   assign on_diag  = (IW'(row_q) == IW'(col_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q <= '0;
         col_q <= '0;
      end else if (!step) begin
         row_q <= '0;
         col_q <= '0;
      end else if (col_end) begin
         col_q <= '0;
         row_q <= row_end ? '0 : row_q + 1'b1;
      end else begin
         col_q <= col_q + 1'b1;
      end
   end

endmodule

// File: rtl/pixel_fix.sv
module pixel_fix #(
   parameter int unsigned PIX_W = 10
) (
   input  logic [PIX_W-1:0] raw,
   output logic [PIX_W-1:0] fixed
);
   localparam logic [PIX_W-1:0] BAD_CODE = '1;

   always_comb begin
      if (raw == BAD_CODE) begin
         fixed = BAD_CODE - 1'b1;
      end else begin
         fixed = raw;
      end
   end

endmodule

// File: rtl/diag_accum.sv
module diag_accum #(
   parameter int unsigned PIX_W = 10,
   parameter int unsigned SUM_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             add_en,
   input  logic [PIX_W-1:0] pix,
   output logic [SUM_W-1:0] sum
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum <= '0;
      end else if (clr) begin
         sum <= '0;
      end else if (add_en) begin
         sum <= sum + SUM_W'(pix);
      end
   end

endmodule

// File: rtl/img_diag_capture.sv
module img_diag_capture #(
   parameter int unsigned PIX_W         = 10,
   parameter int unsigned ROWS          = 1024,
   parameter int unsigned COLS          = 1024,
   parameter int unsigned SUM_W         = 20,
   parameter int unsigned CLK_PERIOD_NS = 10,
   parameter int unsigned REQ_NS        = 200
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             abort,
   input  logic [PIX_W-1:0] pix_in,
   output logic             frame_req_n,
   output logic             busy_rx,
   output logic             sum_ready,
   output logic [SUM_W-1:0] diag_sum
);
   import imgcap_pkg::*;

   localparam int unsigned REQ_CYC  = div_ceil(REQ_NS, CLK_PERIOD_NS);
   localparam int unsigned DIAG_LEN = (ROWS < COLS) ? ROWS : COLS;
   localparam int unsigned NEED_W   = PIX_W + bits_for(DIAG_LEN);

   generate
      if (PIX_W < 2) begin : g_chk_pix
         $error("img_diag_capture: PIX_W must be at least 2");
      end
      if (ROWS < 2 || COLS < 2) begin : g_chk_dim
         $error("img_diag_capture: ROWS and COLS must be at least 2");
      end
      if (SUM_W < NEED_W) begin : g_chk_sum
         $error("img_diag_capture: SUM_W too narrow for the diagonal sum");
      end
      if (CLK_PERIOD_NS == 0 || REQ_NS == 0) begin : g_chk_time
         $error("img_diag_capture: timing parameters must be nonzero");
      end
   endgenerate

   cap_state_t       state_q;
   cap_state_t       state_d;
   logic             req_last;
   logic             pix_last;
   logic             pix_diag;
   logic [PIX_W-1:0] pix_ok;
   logic [SUM_W-1:0] acc_sum;

   req_pulse_timer #(
      .PULSE_CYC(REQ_CYC)
   ) u_req_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (state_q == CAP_REQ),
      .last (req_last)
   );

   raster_tracker #(
      .ROWS(ROWS),
      .COLS(COLS)
   ) u_raster (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (state_q == CAP_RECV),
      .on_diag (pix_diag),
      .last_pix(pix_last)
   );

   pixel_fix #(
      .PIX_W(PIX_W)
   ) u_fix (
      .raw  (pix_in),
      .fixed(pix_ok)
   );

   diag_accum #(
      .PIX_W(PIX_W),
      .SUM_W(SUM_W)
   ) u_accum (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (state_q == CAP_REQ),
      .add_en((state_q == CAP_RECV) && pix_diag),
      .pix   (pix_ok),
      .sum   (acc_sum)
   );

   always_comb begin
      state_d = state_q;
      if (abort) begin
         state_d = CAP_IDLE;
      end else begin
         unique case (state_q)
            CAP_IDLE: if (start)    state_d = CAP_REQ;
            CAP_REQ:  if (req_last) state_d = CAP_RECV;
            CAP_RECV: if (pix_last) state_d = CAP_HOLD;
            CAP_HOLD: if (start)    state_d = CAP_REQ;
            default:                state_d = CAP_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CAP_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   assign frame_req_n = (state_q != CAP_REQ);
   assign busy_rx     = (state_q == CAP_RECV);
   assign sum_ready   = (state_q == CAP_HOLD);
   assign diag_sum    = sum_ready ? acc_sum : '1;

endmodule

// File: rtl/img_diag_capture_chk.sv
module img_diag_capture_chk #(
   parameter int unsigned SUM_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             abort,
   input logic             frame_req_n,
   input logic             busy_rx,
   input logic             sum_ready,
   input logic [SUM_W-1:0] diag_sum
);
   // R9
   abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (frame_req_n && !busy_rx && !sum_ready));

   // R7
   not_ready_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sum_ready |-> (diag_sum == {SUM_W{1'b1}}));

   // R2
   req_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frame_req_n) |-> ($past(start) && !$past(abort)));

   // R3
   rx_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_rx) |-> !$past(frame_req_n));

   // R8
   ready_after_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sum_ready) |-> $past(busy_rx));

   // R8
   ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sum_ready && !abort && !start) |=> (sum_ready && $stable(diag_sum)));

   // R3
   flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({!frame_req_n, busy_rx, sum_ready}));

endmodule

bind img_diag_capture img_diag_capture_chk #(
   .SUM_W(SUM_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .abort      (abort),
   .frame_req_n(frame_req_n),
   .busy_rx    (busy_rx),
   .sum_ready  (sum_ready),
   .diag_sum   (diag_sum)
);

// File: tb/img_diag_capture_tb.sv
module img_diag_capture_tb;
   localparam int CLK_NS  = 40;
   localparam int PW      = 4;
   localparam int NR      = 4;
   localparam int NC      = 4;
   localparam int SW      = 8;
   localparam int RNS     = 200;
   localparam int EXP_REQ = (RNS + CLK_NS - 1) / CLK_NS;
   localparam int ONES    = (1 << SW) - 1;
   localparam int PMAX    = (1 << PW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          abort = 1'b0;
   logic [PW-1:0] pix_in = '0;
   logic          frame_req_n;
   logic          busy_rx;
   logic          sum_ready;
   logic [SW-1:0] diag_sum;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   img_diag_capture #(
      .PIX_W(PW), .ROWS(NR), .COLS(NC), .SUM_W(SW),
      .CLK_PERIOD_NS(CLK_NS), .REQ_NS(RNS)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .pix_in(pix_in),
      .frame_req_n(frame_req_n), .busy_rx(busy_rx), .sum_ready(sum_ready),
      .diag_sum(diag_sum)
   );

   always #(CLK_NS/2) clk = ~clk;

   task automatic check(input string req, input int actual, input int expected);
      n_checks++;
      if (actual != expected) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
      end
   endtask

   function automatic int pix_of(input int pat, input int r, input int c);
      case (pat)
         0: return PMAX;
         1: return (r * NC + c) % (PMAX + 1);
         2: return (r * 7 + c * 3 + 5) % (PMAX + 1);
         3: return (r == c) ? PMAX - r : (r + c);
         default: return (r * 5 + c * 11 + pat) % (PMAX + 1);
      endcase
   endfunction

   function automatic int corrected(input int v);
      return (v == PMAX) ? PMAX - 1 : v;
   endfunction

   // Runs one frame. abort_at < 0: no abort. go_at: pixel index at which start is pulsed while busy.
   task automatic run_frame(input int pat, input int abort_at, input int go_at);
      int low_cnt = 0;
      int exp_sum = 0;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (frame_req_n == 1'b0 && low_cnt < 100) begin
         low_cnt++;
         check("R7 ones during request", diag_sum, ONES);
         @(negedge clk);
      end
      check("R2 request pulse length", low_cnt, EXP_REQ);
      check("R3 receiving after pulse", busy_rx, 1);
      for (int r = 0; r < NR; r++) begin
         for (int c = 0; c < NC; c++) begin
            int idx = r * NC + c;
            if (idx == abort_at) begin
               abort = 1'b1;
               @(negedge clk);
               abort = 1'b0;
               check("R9 req_n after abort", frame_req_n, 1);
               check("R9 busy_rx after abort", busy_rx, 0);
               check("R9 sum_ready after abort", sum_ready, 0);
               check("R9 checksum after abort", diag_sum, ONES);
               return;
            end
            check("R3 receiving each pixel", busy_rx, 1);
            if (idx == 1) check("R7 ones while receiving", diag_sum, ONES);
            pix_in = PW'(pix_of(pat, r, c));
            start  = (idx == go_at);
            if (r == c) exp_sum += corrected(pix_of(pat, r, c));
            @(negedge clk);
            start = 1'b0;
            if (idx == go_at) check("R2 start ignored while busy", frame_req_n, 1);
         end
      end
      check("R8 sum_ready after last pixel", sum_ready, 1);
      check("R3 receiving ended", busy_rx, 0);
      check("R6 R5 diagonal sum", diag_sum, exp_sum);
      repeat (3) @(negedge clk);
      check("R8 sum held", diag_sum, exp_sum);
      check("R8 ready held", sum_ready, 1);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin : stim
      repeat (2) @(negedge clk);
      // R1
      check("R1 req_n reset", frame_req_n, 1);
      check("R1 busy_rx reset", busy_rx, 0);
      check("R1 sum_ready reset", sum_ready, 0);
      check("R1 checksum reset", diag_sum, ONES);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle holds", frame_req_n, 1);

      // R5 R6: every pixel illegal
      run_frame(0, -1, -1);
      // R10 R4: new frames from completed state, fresh sums
      for (int p = 1; p < 6; p++) run_frame(p, -1, -1);
      // R2: start pulsed mid-reception
      run_frame(2, -1, 6);
      // R9: abort in held state
      @(negedge clk);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      check("R9 ready cleared from hold", sum_ready, 0);
      check("R9 checksum ones from hold", diag_sum, ONES);
      // R9: abort mid-frame, then R10 clean restart
      run_frame(3, 7, -1);
      run_frame(3, -1, -1);
      run_frame(1, 0, -1);
      run_frame(4, -1, -1);
      // R9: abort during request pulse, with start together
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R2 request started", frame_req_n, 0);
      abort = 1'b1;
      start = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      start = 1'b0;
      check("R9 abort during request", frame_req_n, 1);
      check("R9 no reception after abort", busy_rx, 0);
      repeat (EXP_REQ + 2) @(negedge clk);
      check("R9 stays idle", frame_req_n, 1);
      run_frame(0, -1, -1);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule